// File: doc/BRIEF.md
# DDR2 Command Decoder with Power-State Tracking

This block watches a DDR2-style control bus: clock enable, chip select, RAS, CAS, WE, two bank-select bits and the address bus. It samples them on every rising clock edge and turns each sampled cycle into one registered command code. Bank, row and column fields come with the code. A separate output tracks the device power state: normal, power-down or self-refresh. The block keeps the clock-enable level from the previous cycle, so the same pin pattern can decode as an ordinary command, an entry into a low-power state or an exit from one.

A bus monitor or controller-side model uses it to see what the memory device would take each cycle to be. Any cycle that fits no valid command raises an illegal flag for exactly one cycle. All outputs are registered and appear in the cycle after the one sampled.

Top module: `ddr2CmdTracker`

## Requirements
- R1: After reset, cmdCode is 0 (none), pwrState is 0 (normal) and illegalCmd is 0. The previous clock-enable level is taken as low, so a sampled cycle whose previous clock enable was low, in the normal state, yields cmdCode 0 and no illegal flag.
- R2: If clock enable is high in both cycles and chip select, RAS, CAS and WE are all low, the cycle is a mode-register write, cmdCode 3. bankOut carries the register select: 0 is the main register, 1 is extended register 1, 2 is extended register 2. A select of 3 is illegal.
- R3: Chip select, RAS and CAS low with WE high gives auto-refresh (cmdCode 4) when clock enable is high in both cycles. It gives self-refresh entry (cmdCode 5, pwrState 2) when clock enable falls.
- R4: Chip select and RAS low, CAS high and WE low is a precharge. With address bit 10 low it is a single-bank precharge, cmdCode 9, with bankOut equal to the bank bits. With bit 10 high it is precharge-all, cmdCode 10, with bankOut 0 whatever the bank bits are.
- R5: Chip select and RAS low with CAS and WE high is activate, cmdCode 11. bankOut is the bank bits and rowOut is the full address. rowOut is 0 for every other command.
- R6: Chip select and CAS low with RAS high is a column access. WE low is a write (cmdCode 12, or 13 with auto-precharge). WE high is a read (cmdCode 14, or 15 with auto-precharge). Auto-precharge is selected by address bit 10, and colOut is the address with bit 10 cleared.
- R7: With clock enable high in both cycles, chip select high is deselect (cmdCode 1) and chip select low with RAS, CAS and WE high is no-operation (cmdCode 2). For both, bankOut, rowOut and colOut are 0.
- R8: If clock enable falls on a deselect or no-operation pattern, the cycle is power-down entry: cmdCode 7, and pwrState becomes 1 in the same output cycle. In power-down, a cycle with clock enable high and a deselect or no-operation pattern is power-down exit: cmdCode 8, and pwrState returns to 0.
- R9: In power-down or self-refresh, every cycle with clock enable low yields cmdCode 0 and no illegal flag, whatever the other pins carry, and pwrState is held.
- R10: In self-refresh, a cycle with clock enable high and a deselect or no-operation pattern is self-refresh exit: cmdCode 6, and pwrState returns to 0.
- R11: A cycle that fits no command gives cmdCode 0 and illegalCmd 1 for that one cycle only. Such cycles include: chip select low with RAS and CAS high and WE low; clock enable falling on a pattern other than deselect, no-operation or refresh; clock enable high in a low-power state on a pattern other than deselect or no-operation. After the last case the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable level this cycle |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select bits |
| addr | input | ADDR_W | Address bus |
| cmdCode | output | 4 | Decoded command code |
| illegalCmd | output | 1 | One-cycle flag for an unmatched pattern |
| bankOut | output | BANK_W | Bank field of the command |
| rowOut | output | ADDR_W | Row field for activate |
| colOut | output | ADDR_W | Column field, bit 10 cleared |
| pwrState | output | 2 | 0 normal, 1 power-down, 2 self-refresh |

## Verification
A wrong stored clock-enable level shows at the next sampled cycle. A deselect becomes a spurious power-down entry, or a real entry decodes as a plain no-operation. A wrong tracked power state shows once clock enable comes back high: the exit is reported as the wrong kind, or the exit never arrives and the following cycles keep decoding as cmdCode 0. Field faults show directly in the bankOut, rowOut and colOut values one cycle after the command is sampled.

// File: rtl/ddr2CmdPkg.sv
package ddr2CmdPkg;

  typedef enum logic [3:0] {
    CMD_NONE   = 4'd0,
    CMD_DESEL  = 4'd1,
    CMD_NOP    = 4'd2,
    CMD_MRS    = 4'd3,
    CMD_REF    = 4'd4,
    CMD_SRE    = 4'd5,
    CMD_SRX    = 4'd6,
    CMD_PDE    = 4'd7,
    CMD_PDX    = 4'd8,
    CMD_PRE    = 4'd9,
    CMD_PREALL = 4'd10,
    CMD_ACT    = 4'd11,
    CMD_WR     = 4'd12,
    CMD_WRA    = 4'd13,
    CMD_RD     = 4'd14,
    CMD_RDA    = 4'd15
  } cmdE;

  typedef enum logic [1:0] {
    PWR_NORM = 2'd0,
    PWR_PD   = 2'd1,
    PWR_SR   = 2'd2
  } pwrE;

  // strobes from control to field datapath
  typedef struct packed {
    logic loadBank;
    logic loadRow;
    logic loadCol;
  } fieldStrbT;

endpackage

// File: rtl/ddr2CmdCtrl.sv
module ddr2CmdCtrl
  import ddr2CmdPkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] ba,
  input  logic              a10,
  output cmdE               cmdQ,
  output logic              illegalQ,
  output pwrE               pwrQ,
  output fieldStrbT         strb
);

  localparam logic [BANK_W-1:0] MR_BAD = BANK_W'(3);

  logic      prevCke;
  cmdE       cmdNext;
  logic      illNext;
  pwrE       pwrNext;
  logic      idlePat;
  logic      refPat;

  assign idlePat = csN | (rasN & casN & weN);
  assign refPat  = ~csN & ~rasN & ~casN & weN;

  always_comb begin
    cmdNext = CMD_NONE;
    illNext = 1'b0;
    pwrNext = pwrQ;
    strb    = '0;
    unique case (pwrQ)
      PWR_NORM: begin
        if (prevCke && cke) begin
          if (csN) begin
            cmdNext = CMD_DESEL;
          end else begin
            unique case ({rasN, casN, weN})
              3'b000: begin
                if (ba == MR_BAD) illNext = 1'b1;
                else begin
                  cmdNext = CMD_MRS;
                  strb.loadBank = 1'b1;
                end
              end
              3'b001: cmdNext = CMD_REF;
              3'b010: begin
                if (a10) cmdNext = CMD_PREALL;
                else begin
                  cmdNext = CMD_PRE;
                  strb.loadBank = 1'b1;
                end
              end
              3'b011: begin
                cmdNext = CMD_ACT;
                strb.loadBank = 1'b1;
                strb.loadRow  = 1'b1;
              end
              3'b100, 3'b101: begin
                cmdNext = weN ? (a10 ? CMD_RDA : CMD_RD)
                              : (a10 ? CMD_WRA : CMD_WR);
                strb.loadBank = 1'b1;
                strb.loadCol  = 1'b1;
              end
              3'b110: illNext = 1'b1;
              default: cmdNext = CMD_NOP;
            endcase
          end
        end else if (prevCke && !cke) begin
          if (idlePat) begin
            cmdNext = CMD_PDE;
            pwrNext = PWR_PD;
          end else if (refPat) begin
            cmdNext = CMD_SRE;
            pwrNext = PWR_SR;
          end else begin
            illNext = 1'b1;
          end
        end
      end
      default: begin
        if (cke) begin
          if (idlePat) begin
            cmdNext = (pwrQ == PWR_SR) ? CMD_SRX : CMD_PDX;
            pwrNext = PWR_NORM;
          end else begin
            illNext = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCke  <= 1'b0;
      cmdQ     <= CMD_NONE;
      illegalQ <= 1'b0;
      pwrQ     <= PWR_NORM;
    end else begin
      prevCke  <= cke;
      cmdQ     <= cmdNext;
      illegalQ <= illNext;
      pwrQ     <= pwrNext;
    end
  end

  AST_ILLEGAL_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    illegalQ |-> cmdQ == CMD_NONE); // R11
  AST_PD_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rstN)
    cmdQ == CMD_PDE |-> pwrQ == PWR_PD); // R8
  AST_SR_EXIT_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    cmdQ == CMD_SRX |-> $past(pwrQ) == PWR_SR && pwrQ == PWR_NORM); // R10
  AST_LOWPWR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ != PWR_NORM && $past(pwrQ) == pwrQ) |-> cmdQ == CMD_NONE); // R9

endmodule

// File: rtl/ddr2CmdFields.sv
module ddr2CmdFields
  import ddr2CmdPkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  fieldStrbT         strb,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bankQ,
  output logic [ADDR_W-1:0] rowQ,
  output logic [ADDR_W-1:0] colQ
);

  localparam int AP_BIT = 10;
  localparam logic [ADDR_W-1:0] COL_MASK = ~(ADDR_W'(1) << AP_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ <= '0;
      rowQ  <= '0;
      colQ  <= '0;
    end else begin
      bankQ <= strb.loadBank ? ba : '0;
      rowQ  <= strb.loadRow ? addr : '0;
      colQ  <= strb.loadCol ? (addr & COL_MASK) : '0;
    end
  end

  AST_COL_NO_AP_BIT: assert property (@(posedge clk) disable iff (!rstN)
    colQ[AP_BIT] == 1'b0); // R6
  AST_ROW_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    rowQ != '0 |-> $past(strb.loadRow)); // R5

endmodule

// File: rtl/ddr2CmdTracker.sv
module ddr2CmdTracker
  import ddr2CmdPkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmdCode,
  output logic              illegalCmd,
  output logic [BANK_W-1:0] bankOut,
  output logic [ADDR_W-1:0] rowOut,
  output logic [ADDR_W-1:0] colOut,
  output logic [1:0]        pwrState
);

  cmdE       cmdQ;
  pwrE       pwrQ;
  fieldStrbT strb;

  ddr2CmdCtrl #(.BANK_W(BANK_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .a10(addr[10]),
    .cmdQ(cmdQ), .illegalQ(illegalCmd), .pwrQ(pwrQ), .strb(strb)
  );

  ddr2CmdFields #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) uFields (
    .clk(clk), .rstN(rstN), .strb(strb), .ba(ba), .addr(addr),
    .bankQ(bankOut), .rowQ(rowOut), .colQ(colOut)
  );

  assign cmdCode  = cmdQ;
  assign pwrState = pwrQ;

endmodule

// File: tb/tb_ddr2CmdTracker.sv
module tb_ddr2CmdTracker;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] P_NOP = 4'b0111, P_DES = 4'b1000, P_MRS = 4'b0000,
    P_REF = 4'b0001, P_PRE = 4'b0010, P_ACT = 4'b0011, P_WR = 4'b0100,
    P_RD = 4'b0101, P_BAD = 4'b0110;

  logic clk = 0, rstN = 0, cke = 0, csN = 1, rasN = 1, casN = 1, weN = 1;
  logic [1:0] ba = 0;
  logic [13:0] addr = 0;
  logic [3:0] cmdCode;
  logic illegalCmd;
  logic [1:0] bankOut, pwrState;
  logic [13:0] rowOut, colOut;
  int checks = 0, errors = 0;
  logic done = 0;

  ddr2CmdTracker dut (.clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr), .cmdCode(cmdCode),
    .illegalCmd(illegalCmd), .bankOut(bankOut), .rowOut(rowOut),
    .colOut(colOut), .pwrState(pwrState));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(logic k, logic [3:0] p, logic [1:0] b, logic [13:0] a);
    cke = k; {csN, rasN, casN, weN} = p; ba = b; addr = a;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect3(string req, int c, int ill, int pw);
    chk({req, " cmd"}, cmdCode, c);
    chk({req, " ill"}, illegalCmd, ill);
    chk({req, " pwr"}, pwrState, pw);
  endtask

  task automatic tReset();
    expect3("R1 reset", 0, 0, 0);
    cyc(1, P_NOP, 0, 0);
    expect3("R1 prev low", 0, 0, 0);
  endtask

  task automatic tNopDesel();
    cyc(1, P_ACT, 1, 14'h0123);
    cyc(1, P_NOP, 1, 14'h0123);
    expect3("R7 nop", 2, 0, 0);
    chk("R7 nop row", rowOut, 0);
    chk("R7 nop bank", bankOut, 0);
    cyc(1, P_DES, 2, 14'h3FFF);
    expect3("R7 desel", 1, 0, 0);
    chk("R7 desel col", colOut, 0);
  endtask

  task automatic tMrs();
    for (int i = 0; i < 3; i++) begin
      cyc(1, P_MRS, 2'(i), 14'h0042);
      expect3("R2 mrs", 3, 0, 0);
      chk("R2 mrs sel", bankOut, i);
    end
    cyc(1, P_MRS, 3, 0);
    expect3("R2 mrs bad sel", 0, 1, 0);
  endtask

  task automatic tRef();
    cyc(1, P_REF, 0, 0);
    expect3("R3 refresh", 4, 0, 0);
  endtask

  task automatic tPre();
    cyc(1, P_PRE, 2, 14'h0000);
    expect3("R4 pre single", 9, 0, 0);
    chk("R4 pre bank", bankOut, 2);
    cyc(1, P_PRE, 3, 14'h0400);
    expect3("R4 pre all", 10, 0, 0);
    chk("R4 pre all bank", bankOut, 0);
  endtask

  task automatic tAct();
    cyc(1, P_ACT, 1, 14'h2ABC);
    expect3("R5 act", 11, 0, 0);
    chk("R5 act bank", bankOut, 1);
    chk("R5 act row", rowOut, 14'h2ABC);
    chk("R5 act col", colOut, 0);
  endtask

  task automatic tCol();
    cyc(1, P_WR, 3, 14'h0455);
    expect3("R6 wra", 13, 0, 0);
    chk("R6 wra col", colOut, 14'h0055);
    chk("R6 wra bank", bankOut, 3);
    cyc(1, P_WR, 0, 14'h0055);
    expect3("R6 wr", 12, 0, 0);
    cyc(1, P_RD, 2, 14'h07FF);
    expect3("R6 rda", 15, 0, 0);
    chk("R6 rda col", colOut, 14'h03FF);
    chk("R6 rda row", rowOut, 0);
    cyc(1, P_RD, 1, 14'h0001);
    expect3("R6 rd", 14, 0, 0);
  endtask

  task automatic tIllegal();
    cyc(1, P_BAD, 0, 0);
    expect3("R11 bad pattern", 0, 1, 0);
    cyc(1, P_NOP, 0, 0);
    expect3("R11 one cycle", 2, 0, 0);
    cyc(0, P_ACT, 0, 0);
    expect3("R11 fall on act", 0, 1, 0);
    cyc(1, P_NOP, 0, 0);
    expect3("R1 prev low again", 0, 0, 0);
  endtask

  task automatic tPowerDown();
    cyc(0, P_NOP, 0, 0);
    expect3("R8 pd entry", 7, 0, 1);
    cyc(0, P_ACT, 1, 14'h1111);
    expect3("R9 pd ignore", 0, 0, 1);
    chk("R9 pd row", rowOut, 0);
    cyc(0, P_DES, 0, 0);
    expect3("R9 pd ignore desel", 0, 0, 1);
    cyc(1, P_ACT, 0, 0);
    expect3("R11 pd bad exit", 0, 1, 1);
    cyc(1, P_NOP, 0, 0);
    expect3("R8 pd exit", 8, 0, 0);
  endtask

  task automatic tSelfRefresh();
    cyc(1, P_NOP, 0, 0);
    cyc(0, P_REF, 0, 0);
    expect3("R3 sr entry", 5, 0, 2);
    cyc(0, P_REF, 0, 0);
    expect3("R9 sr ignore", 0, 0, 2);
    cyc(1, P_DES, 0, 0);
    expect3("R10 sr exit", 6, 0, 0);
    cyc(1, P_NOP, 0, 0);
    expect3("R10 after exit", 2, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tNopDesel();
    tMrs();
    tRef();
    tPre();
    tAct();
    tCol();
    tIllegal();
    tPowerDown();
    tSelfRefresh();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule